// File: doc/BRIEF.md
# Self-Triggered Multichannel Acquisition Sequencer

This block runs autonomous acquisition for a bank of independent detector channels. No global trigger is used. Each channel watches its own discriminator line. On every rising edge that arrives while acquisition is enabled, the channel claims one of its two analog storage cells. The storage is modelled as occupancy state. The cell is tagged with the shared coarse timestamp, which is a Gray-coded count that steps once every fixed number of clock cycles.

Occupied cells wait for a single shared converter. A conversion engine picks channels in rotating order and issues one request at a time. It then places the returned code, together with the channel number, the cell index and the timestamp, into one output word on a ready/valid stream. Only channels that actually stored a hit produce words. A cell returns to the free pool only when its word has been accepted downstream.

A small manager holds the block idle, acquiring or draining. A start pulse opens acquisition. A stop pulse closes it to new hits. The block then keeps converting and streaming until every stored cell has been read out, and only then returns to idle.

Top module: `selftrig_acq`

## Requirements
- R1: After reset, running_o, draining_o, conv_req_o and out_valid_o are low and every overflow_o bit is 0.
- R2: A start_i pulse seen in idle puts the block in acquisition on the next cycle (running_o high). A stop_i pulse seen in acquisition moves it to draining (draining_o high). start_i is ignored while acquiring or draining. stop_i is ignored in idle.
- R3: A channel stores a sample only on a rising edge of its hit_i bit sampled while acquiring. A level held high yields one sample. Edges sampled in idle or while draining are ignored.
- R4: Within a channel, stored cells are written alternately with cell index 0, 1, 0, 1, ... starting from 0 after reset.
- R5: The coarse timestamp is the Gray code (b ^ b>>1) of a 24-bit binary count that starts at 0 at reset and increments once every TICK_DIV cycles. The value latched with a sample is the one current at the edge where the hit is sampled.
- R6: A rising edge sampled while a channel already holds two cells is dropped and sets overflow_o for that channel. The flag stays set until the next accepted start_i.
- R7: Only one conversion is outstanding at a time. conv_req_o stays high with conv_ch_o and conv_cell_o stable until conv_done_i is sampled. No new request is raised while an output word is pending.
- R8: Channels with stored cells are served in rotating order. After channel c is read out, the search for the next request starts at channel c+1, wrapping to 0.
- R9: Within a channel, the oldest stored cell is converted and read out first.
- R10: out_data_o holds the channel at bits [38:35], the cell index at bit [34], the timestamp at [33:10] and the converted code at [9:0]. out_valid_o and out_data_o hold until out_ready_i is high, and that handshake frees the cell.
- R11: While draining, the block returns to idle at the first clock edge at which no cell is occupied. In idle, no request and no output word is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start acquisition pulse |
| stop_i | input | 1 | Stop acquisition pulse |
| hit_i | input | 16 | Per-channel discriminator lines |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | 4 | Channel being converted |
| conv_cell_o | output | 1 | Cell being converted |
| conv_done_i | input | 1 | Conversion finished |
| conv_code_i | input | 10 | Converted code, valid with conv_done_i |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 39 | Output word |
| running_o | output | 1 | Acquisition phase |
| draining_o | output | 1 | Draining phase |
| overflow_o | output | 16 | Per-channel sticky dropped-hit flag |

## Verification
On every cycle, the assertions check the handshake rules: a request and an output word hold steady until they are answered, a request never overlaps a pending word, and the phase moves only along idle, acquiring, draining and back to idle. They also check that an overflow flag clears only on a start taken in idle, and that idle is quiet. The properties cannot judge the content of the stream: which channels appear, in what rotating order, with which cell index and timestamp, and whether a dropped or ignored hit truly left no trace. That is shown by the bench's behavioural model under idle hits, held levels, overflow bursts, back-pressure, draining and long random traffic.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {MGR_IDLE, MGR_RUN, MGR_DRAIN} mgr_state_e;
  typedef enum logic [1:0] {CV_IDLE, CV_REQ, CV_OUT} cv_state_e;
endpackage

// File: rtl/acq_gray_timer.sv
module acq_gray_timer #(
  parameter int TS_W     = 24,
  parameter int TICK_DIV = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] gray_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [TS_W-1:0]  bin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bin_q <= '0;
    end else if (div_q == DIV_W'(TICK_DIV - 1)) begin
      div_q <= '0;
      bin_q <= bin_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign gray_o = bin_q ^ (bin_q >> 1);
endmodule

// File: rtl/acq_chan.sv
module acq_chan #(
  parameter int TS_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_ovf_i,
  input  logic            hit_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            pop_i,
  output logic            pend_o,
  output logic            rd_cell_o,
  output logic [TS_W-1:0] rd_ts_o,
  output logic            ovf_o
);
  logic            hit_q;
  logic [1:0]      cnt_q;
  logic            wr_q, rd_q;
  logic [TS_W-1:0] ts0_q, ts1_q;
  logic            ovf_q;
  logic            rise, take, drop;

  assign rise = hit_i & ~hit_q;
  assign take = en_i & rise & (cnt_q != 2'd2);
  assign drop = en_i & rise & (cnt_q == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      ts0_q <= '0;
      ts1_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      hit_q <= hit_i;
      if (take) begin
        if (wr_q) ts1_q <= ts_i;
        else      ts0_q <= ts_i;
        wr_q <= ~wr_q;
      end
      if (pop_i) rd_q <= ~rd_q;
      case ({take, pop_i})
        2'b10:   cnt_q <= cnt_q + 2'd1;
        2'b01:   cnt_q <= cnt_q - 2'd1;
        default: cnt_q <= cnt_q;
      endcase
      if (clr_ovf_i) ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
    end
  end

  assign pend_o    = (cnt_q != 2'd0);
  assign rd_cell_o = rd_q;
  assign rd_ts_o   = rd_q ? ts1_q : ts0_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/acq_mgr.sv
module acq_mgr
  import acq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       all_empty_i,
  output mgr_state_e state_o,
  output logic       clr_ovf_o
);
  mgr_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= MGR_IDLE;
    else begin
      unique case (st_q)
        MGR_IDLE:  if (start_i)     st_q <= MGR_RUN;
        MGR_RUN:   if (stop_i)      st_q <= MGR_DRAIN;
        MGR_DRAIN: if (all_empty_i) st_q <= MGR_IDLE;
        default:                    st_q <= MGR_IDLE;
      endcase
    end
  end

  assign state_o   = st_q;
  assign clr_ovf_o = (st_q == MGR_IDLE) & start_i;
endmodule

// File: rtl/acq_conv_rr.sv
module acq_conv_rr
  import acq_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int CH_W   = 4,
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [N_CH-1:0]   pend_i,
  input  logic              conv_done_i,
  input  logic [CODE_W-1:0] conv_code_i,
  input  logic              out_ready_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   sel_o,
  output logic [CODE_W-1:0] code_o,
  output logic              out_valid_o,
  output logic [N_CH-1:0]   pop_o
);
  cv_state_e         st_q;
  logic [CH_W-1:0]   rr_q, sel_q, pick;
  logic [CODE_W-1:0] code_q;
  logic              found;

  // first pending channel at or after the rotating pointer
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (!found && pend_i[(int'(rr_q) + i) % N_CH]) begin
        found = 1'b1;
        pick  = CH_W'((int'(rr_q) + i) % N_CH);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CV_IDLE;
      rr_q   <= '0;
      sel_q  <= '0;
      code_q <= '0;
    end else begin
      unique case (st_q)
        CV_IDLE: if (en_i && found) begin
          sel_q <= pick;
          st_q  <= CV_REQ;
        end
        CV_REQ: if (conv_done_i) begin
          code_q <= conv_code_i;
          st_q   <= CV_OUT;
        end
        CV_OUT: if (out_ready_i) begin
          st_q <= CV_IDLE;
          rr_q <= (int'(sel_q) == N_CH - 1) ? '0 : sel_q + 1'b1;
        end
        default: st_q <= CV_IDLE;
      endcase
    end
  end

  always_comb begin
    pop_o = '0;
    if (st_q == CV_OUT && out_ready_i) pop_o[sel_q] = 1'b1;
  end

  assign conv_req_o  = (st_q == CV_REQ);
  assign out_valid_o = (st_q == CV_OUT);
  assign sel_o       = sel_q;
  assign code_o      = code_q;
endmodule

// File: rtl/selftrig_acq.sv
module selftrig_acq
  import acq_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int CH_W     = $clog2(N_CH),
  parameter int TS_W     = 24,
  parameter int CODE_W   = 10,
  parameter int TICK_DIV = 20,
  parameter int DATA_W   = CH_W + 1 + TS_W + CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [N_CH-1:0]   hit_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic              conv_cell_o,
  input  logic              conv_done_i,
  input  logic [CODE_W-1:0] conv_code_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              running_o,
  output logic              draining_o,
  output logic [N_CH-1:0]   overflow_o
);
  mgr_state_e        mgr_st;
  logic              clr_ovf;
  logic [TS_W-1:0]   gray_ts;
  logic [N_CH-1:0]   pend, pop;
  logic              rd_cell [N_CH];
  logic [TS_W-1:0]   rd_ts   [N_CH];
  logic [CH_W-1:0]   sel;
  logic [CODE_W-1:0] code;
  logic              acq_en, cv_en;

  assign acq_en = (mgr_st == MGR_RUN);
  assign cv_en  = (mgr_st != MGR_IDLE);

  acq_mgr i_mgr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .all_empty_i (~|pend),
    .state_o     (mgr_st),
    .clr_ovf_o   (clr_ovf)
  );

  acq_gray_timer #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gray_o (gray_ts)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    acq_chan #(.TS_W(TS_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (acq_en),
      .clr_ovf_i (clr_ovf),
      .hit_i     (hit_i[c]),
      .ts_i      (gray_ts),
      .pop_i     (pop[c]),
      .pend_o    (pend[c]),
      .rd_cell_o (rd_cell[c]),
      .rd_ts_o   (rd_ts[c]),
      .ovf_o     (overflow_o[c])
    );
  end

  acq_conv_rr #(.N_CH(N_CH), .CH_W(CH_W), .CODE_W(CODE_W)) i_conv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cv_en),
    .pend_i      (pend),
    .conv_done_i (conv_done_i),
    .conv_code_i (conv_code_i),
    .out_ready_i (out_ready_i),
    .conv_req_o  (conv_req_o),
    .sel_o       (sel),
    .code_o      (code),
    .out_valid_o (out_valid_o),
    .pop_o       (pop)
  );

  assign conv_ch_o   = sel;
  assign conv_cell_o = rd_cell[sel];
  assign out_data_o  = {sel, rd_cell[sel], rd_ts[sel], code};
  assign running_o   = (mgr_st == MGR_RUN);
  assign draining_o  = (mgr_st == MGR_DRAIN);
endmodule

// File: rtl/selftrig_acq_chk.sv
module selftrig_acq_chk #(
  parameter int N_CH   = 16,
  parameter int CH_W   = 4,
  parameter int DATA_W = 39
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              conv_req_o,
  input logic [CH_W-1:0]   conv_ch_o,
  input logic              conv_cell_o,
  input logic              conv_done_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              running_o,
  input logic              draining_o,
  input logic [N_CH-1:0]   overflow_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_ch_o) && $stable(conv_cell_o)); // R7
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !conv_req_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R10
  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(running_o && draining_o)); // R2
  AST_RUN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> draining_o); // R2
  AST_DRAIN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(draining_o) |-> !running_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !draining_o |-> !conv_req_o && !out_valid_o); // R11
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(overflow_o) & ~overflow_o) |-> $past(start_i) && !$past(running_o) && !$past(draining_o)); // R6
endmodule

bind selftrig_acq selftrig_acq_chk #(.N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .conv_req_o  (conv_req_o),
  .conv_ch_o   (conv_ch_o),
  .conv_cell_o (conv_cell_o),
  .conv_done_i (conv_done_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .running_o   (running_o),
  .draining_o  (draining_o),
  .overflow_o  (overflow_o)
);

// File: tb/test_selftrig_acq.sv
`timescale 1ns/1ps
module test_selftrig_acq;
  localparam int NC = 16;
  localparam int TICK = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [15:0] hit_i = '0;
  logic        conv_req_o, conv_cell_o, conv_done_i = 1'b0;
  logic [3:0]  conv_ch_o;
  logic [9:0]  conv_code_i = '0;
  logic        out_valid_o, out_ready_i = 1'b1;
  logic [38:0] out_data_o;
  logic        running_o, draining_o;
  logic [15:0] overflow_o;

  always #2.5 clk = ~clk;

  selftrig_acq i_selftrig_acq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i), .hit_i(hit_i),
    .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o), .conv_cell_o(conv_cell_o),
    .conv_done_i(conv_done_i), .conv_code_i(conv_code_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .running_o(running_o), .draining_o(draining_o), .overflow_o(overflow_o));

  int checks = 0, fails = 0;
  int rdy_mode = 0; // 0 always ready, 1 random, 2 never
  int adc_cnt = 0, adc_lat = 2;

  // behavioural reference
  int          m_st = 0;   // 0 idle, 1 run, 2 drain
  int          m_cv = 0;   // 0 idle, 1 request, 2 word pending
  int          m_sel = 0, m_rr = 0, m_div = 0;
  int unsigned m_bin = 0;
  logic [9:0]  m_code = '0;
  bit          m_hq [NC];
  bit          m_wr [NC];
  bit          m_ovf [NC];
  int unsigned q_ts [NC][$];
  bit          q_cell [NC][$];

  function automatic int unsigned gray(int unsigned b);
    return (b ^ (b >> 1)) & 32'hFF_FFFF;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int unsigned ts_now = gray(m_bin);
    bit empty = 1'b1;
    int pop_ch = -1;
    int st_pre = m_st;
    for (int c = 0; c < NC; c++) if (q_ts[c].size() != 0) empty = 1'b0;
    case (m_cv)
      0: if (st_pre != 0) begin
        for (int i = 0; i < NC; i++) begin
          int k = (m_rr + i) % NC;
          if (m_cv == 0 && q_ts[k].size() != 0) begin m_sel = k; m_cv = 1; end
        end
      end
      1: if (conv_done_i) begin m_code = conv_code_i; m_cv = 2; end
      default: if (out_ready_i) begin pop_ch = m_sel; m_cv = 0; m_rr = (m_sel + 1) % NC; end
    endcase
    for (int c = 0; c < NC; c++) begin
      if (st_pre == 1 && hit_i[c] && !m_hq[c]) begin
        if (q_ts[c].size() == 2) m_ovf[c] = 1'b1;
        else begin q_ts[c].push_back(ts_now); q_cell[c].push_back(m_wr[c]); m_wr[c] = ~m_wr[c]; end
      end
      m_hq[c] = hit_i[c];
    end
    if (pop_ch >= 0) begin void'(q_ts[pop_ch].pop_front()); void'(q_cell[pop_ch].pop_front()); end
    case (st_pre)
      0: if (start_i) begin m_st = 1; for (int c = 0; c < NC; c++) m_ovf[c] = 1'b0; end
      1: if (stop_i) m_st = 2;
      default: if (empty) m_st = 0;
    endcase
    if (m_div == TICK - 1) begin m_div = 0; m_bin = (m_bin + 1) & 32'hFF_FFFF; end
    else m_div++;
  endtask

  task automatic compare();
    logic [15:0] ovf_e;
    for (int c = 0; c < NC; c++) ovf_e[c] = m_ovf[c];
    chk(running_o == (m_st == 1) && draining_o == (m_st == 2), "R2 R11 phase",
        {running_o, draining_o}, {m_st == 1, m_st == 2});
    chk(overflow_o == ovf_e, "R6 overflow", overflow_o, ovf_e);
    chk(conv_req_o == (m_cv == 1), "R7 request", conv_req_o, m_cv == 1);
    if (m_cv == 1 && conv_req_o)
      chk(conv_ch_o == 4'(m_sel) && conv_cell_o == q_cell[m_sel][0], "R8 R9 request target",
          {conv_ch_o, conv_cell_o}, {4'(m_sel), q_cell[m_sel][0]});
    chk(out_valid_o == (m_cv == 2), "R10 out valid", out_valid_o, m_cv == 2);
    if (m_cv == 2 && out_valid_o) begin
      logic [38:0] e = {4'(m_sel), q_cell[m_sel][0], 24'(q_ts[m_sel][0]), m_code};
      chk(out_data_o == e, "R4 R5 R10 out word", out_data_o, e);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    conv_done_i = 1'b0;
    if (conv_req_o) begin
      adc_cnt++;
      if (adc_cnt >= adc_lat) begin
        conv_done_i = 1'b1;
        conv_code_i = 10'($urandom);
        adc_cnt = 0;
        adc_lat = 1 + int'($urandom % 4);
      end
    end else adc_cnt = 0;
    out_ready_i = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : 1'($urandom % 2);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic pulse_start(); start_i = 1'b1; cycle(); start_i = 1'b0; endtask
  task automatic pulse_stop();  stop_i = 1'b1;  cycle(); stop_i = 1'b0;  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && (running_o || draining_o); i++) cycle();
  endtask

  initial begin
    #750000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!running_o && !draining_o && !conv_req_o && !out_valid_o && overflow_o == 0,
        "R1 reset", {running_o, draining_o, conv_req_o, out_valid_o, overflow_o}, '0);
    rst_ni = 1'b1;

    // R3 hits in idle ignored
    hit_i = 16'h0108; run(2); hit_i = '0; run(10);
    chk(!conv_req_o && !out_valid_o, "R3 idle hit ignored", {conv_req_o, out_valid_o}, '0);

    // R2 start
    pulse_start();
    chk(running_o, "R2 start", running_o, 1);

    // single hit then R10 field check
    hit_i[5] = 1'b1; cycle(); hit_i[5] = 1'b0;
    for (int i = 0; i < 20 && !out_valid_o; i++) cycle();
    chk(out_valid_o && out_data_o[38:35] == 4'd5 && out_data_o[34] == 1'b0, "R10 R4 channel 5 word",
        out_data_o[38:34], {4'd5, 1'b0});
    run(10);

    // R8 simultaneous hits held high (R3 one sample per level)
    rdy_mode = 1;
    hit_i = 16'h8081; run(40); hit_i = '0; run(40);

    // R6 overflow under back-pressure
    rdy_mode = 2;
    for (int p = 0; p < 3; p++) begin hit_i[2] = 1'b1; cycle(); hit_i[2] = 1'b0; cycle(); end
    run(10);
    chk(overflow_o[2] == 1'b1, "R6 overflow set", overflow_o[2], 1);
    rdy_mode = 0; run(30);

    // random traffic
    rdy_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      hit_i = 16'($urandom & $urandom & $urandom & $urandom);
      cycle();
    end
    hit_i = '0;

    // R2 R11 stop and drain; hits and start while draining ignored
    pulse_stop();
    chk(draining_o || (!running_o && !draining_o), "R2 stop", {running_o, draining_o}, 2'b01);
    hit_i = 16'hFFFF; start_i = 1'b1; cycle(); start_i = 1'b0; hit_i = '0;
    chk(!running_o, "R2 start ignored while draining", running_o, 0);
    wait_idle();
    chk(!running_o && !draining_o, "R11 drained to idle", {running_o, draining_o}, '0);
    run(30);
    chk(!out_valid_o && !conv_req_o, "R3 drain hits ignored", {out_valid_o, conv_req_o}, '0);
    chk(overflow_o[2] == 1'b1, "R6 overflow sticky", overflow_o[2], 1);

    // R6 cleared by start
    pulse_start();
    chk(overflow_o == 16'h0, "R6 cleared on start", overflow_o, 0);
    hit_i = 16'h4000; cycle(); hit_i = '0; run(5);
    pulse_stop();
    wait_idle();
    run(5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule